// File: doc/BRIEF.md
# Rising-Edge Triggered DMA Channel Sequencer

This block is one DMA channel that serves a single peripheral request line. A unit of data is moved only after the request line goes from low to high. The block shows each moved unit as a one-cycle strobe. A transfer counter, loaded by software, limits how many units the channel may move in total. The request is first passed through a synchronizer. A rising edge is then detected on the synchronized copy. A request that stays high never causes a second trigger.

There are two modes. In single mode, each trigger moves one unit. In successive mode, one trigger moves units on back-to-back cycles until the counter reaches zero. Dropping the request in the middle of a successive burst does not stop the burst. When the last unit is moved, a done flag is raised. Loading a new nonzero count while the channel is enabled does two things: it clears the done flag, and it re-arms the edge detector, so a request that is already high counts as a fresh edge.

Top module: `dma_edge_seq`

## Requirements
- R1: After `req_i` rises, `ack_o` goes high for the first time in the cycle that follows the third rising clock edge that sees `req_i` high. This delay comes from two synchronizer stages and one output register.
- R2: If `req_i` stays high, only one trigger is taken. The next trigger needs `req_i` to go low and then high again.
- R3: With `mode_i` = 0 (single mode), each trigger gives exactly one `ack_o` pulse of one cycle. Each `ack_o` pulse comes with `cnt_o` going down by one.
- R4: With `mode_i` = 1 (successive mode), one trigger gives `ack_o` pulses on back-to-back cycles until `cnt_o` reaches 0.
- R5: When `cnt_o` is 0, a trigger gives no `ack_o` pulse.
- R6: `done_o` goes high in the same cycle that the last unit brings `cnt_o` to 0. It stays high until a nonzero count is loaded while `en_i` is 1.
- R7: If `req_i` goes low during a successive burst, the burst keeps going and the count is not changed. The only things that change `cnt_o` are moved units and loads.
- R8: A load of a nonzero value while `en_i` is 1 clears `done_o` and re-arms the edge detector. If the request is being held high at that time, it then triggers exactly once.
- R9: If `cnt_load_i` is high in a cycle where a unit would be moved, the load wins. `cnt_o` takes `cnt_val_i`, and no `ack_o` pulse follows for that cycle.
- R10: While `en_i` is 0, no unit is moved. Request edges are ignored, and a burst in progress stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| mode_i | input | 1 | 0 = single mode, 1 = successive mode |
| cnt_load_i | input | 1 | Load strobe for the transfer counter |
| cnt_val_i | input | CNT_W | Count value to load |
| req_i | input | 1 | Peripheral request, asynchronous to the clock |
| ack_o | output | 1 | One-cycle strobe for each unit moved |
| cnt_o | output | CNT_W | Number of units left to move |
| done_o | output | 1 | High when the count has been used up |

## Verification
Two things can land in the same clock cycle: a counter load and a unit move. The bench causes this by starting a successive burst and then asserting the load strobe while the burst is running. This places a load in the cycle that would otherwise have produced the second strobe. The result is judged at the ports. No strobe may appear for that cycle, and the counter must show the loaded value instead of the decremented one. The request is still high at that point, so the load also re-arms the edge detector, and the bench expects a fresh burst for the newly loaded count.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_SUCC   = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[i] <= 1'b0;
          else         sr_q[i] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[i] <= 1'b0;
          else         sr_q[i] <= sr_q[i-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/dma_edge_det.sv
module dma_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rearm_i,
  output logic rise_o
);
  logic prev_q;

  // clearing the history makes a held-high level look like a new edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      prev_q <= 1'b0;
    else if (rearm_i) prev_q <= 1'b0;
    else              prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nz_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - ONE;

  assign cnt_o  = cnt_q;
  assign nz_o   = (cnt_q != '0);
  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic rise_i,
  input  logic cnt_nz_i,
  input  logic cnt_last_i,
  input  logic load_i,
  input  logic load_nz_i,
  output logic move_o,
  output logic rearm_o,
  output logic ack_o,
  output logic done_o
);
  xfer_mode_e mode;
  logic burst_q, ack_q, done_q;
  logic want;

  assign mode    = xfer_mode_e'(mode_i);
  assign want    = rise_i | burst_q;
  // a load takes priority over a move in the same cycle
  assign move_o  = en_i & cnt_nz_i & want & ~load_i;
  assign rearm_o = load_i & load_nz_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      burst_q <= 1'b0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ack_q   <= move_o;
      burst_q <= move_o & (mode == MODE_SUCC) & ~cnt_last_i;
      if (rearm_o)                  done_q <= 1'b0;
      else if (move_o & cnt_last_i) done_q <= 1'b1;
    end

  assign ack_o  = ack_q;
  assign done_o = done_q;
endmodule

// File: rtl/dma_edge_seq.sv
module dma_edge_seq #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_i,
  input  logic             cnt_load_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             req_i,
  output logic             ack_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic req_s, rise, rearm, move, cnt_nz, cnt_last, load_nz;

  assign load_nz = (cnt_val_i != '0);

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  dma_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (req_s),
    .rearm_i(rearm),
    .rise_o (rise)
  );

  dma_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cnt_load_i),
    .val_i (cnt_val_i),
    .dec_i (move),
    .cnt_o (cnt_o),
    .nz_o  (cnt_nz),
    .last_o(cnt_last)
  );

  dma_seq_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .mode_i    (mode_i),
    .rise_i    (rise),
    .cnt_nz_i  (cnt_nz),
    .cnt_last_i(cnt_last),
    .load_i    (cnt_load_i),
    .load_nz_i (load_nz),
    .move_o    (move),
    .rearm_o   (rearm),
    .ack_o     (ack_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/dma_edge_seq_chk.sv
module dma_edge_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             cnt_load_i,
  input logic [CNT_W-1:0] cnt_val_i,
  input logic             ack_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             done_o
);
  assert_ack_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (cnt_o == $past(cnt_o) - 1'b1));

  assert_no_move_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && !cnt_load_i) |=> !ack_o);

  assert_done_at_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (cnt_o == '0));

  assert_count_only_down_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_load_i |=> (cnt_o <= $past(cnt_o)));

  assert_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_load_i |=> (cnt_o == $past(cnt_val_i) && !ack_o));

  assert_disabled_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ack_o);
endmodule

bind dma_edge_seq dma_edge_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .cnt_load_i(cnt_load_i),
  .cnt_val_i (cnt_val_i),
  .ack_o     (ack_o),
  .cnt_o     (cnt_o),
  .done_o    (done_o)
);

// File: tb/dma_edge_seq_test.sv
module dma_edge_seq_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, mode = 1'b0, ld = 1'b0, req = 1'b0;
  logic [CW-1:0] val = '0;
  logic          ack, done;
  logic [CW-1:0] cnt;

  int checks = 0, fails = 0;
  int cyc = 0, last_ack_cyc = -10;

  typedef struct {
    logic [CW-1:0] cnt;
    bit            consec;
    string         tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  dma_edge_seq #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode),
    .cnt_load_i(ld), .cnt_val_i(val), .req_i(req),
    .ack_o(ack), .cnt_o(cnt), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int c, input bit consec, input string tag);
    exp_t e;
    e.cnt = CW'(c); e.consec = consec; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic load(input int v);
    ld = 1'b1; val = CW'(v);
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic pulse(input int hi);
    req = 1'b1;
    repeat (hi) @(negedge clk);
    req = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (12) @(negedge clk);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  always @(posedge clk) cyc++;

  // monitor
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected ack actual=1 expected=0 cnt=%0d", cnt);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cnt == e.cnt, e.tag, cnt, e.cnt);
        if (e.consec) chk(cyc == last_ack_cyc + 1, "R4 back-to-back", cyc - last_ack_cyc, 1);
      end
      last_ack_cyc = cyc;
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ack == 0, "reset ack", ack, 0);
    chk(cnt == 0, "reset cnt", cnt, 0);
    chk(done == 0, "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // single mode, latency and held-high request
    en = 1'b1; mode = 1'b0;
    load(3);
    push(2, 0, "R3 single cnt");
    req = 1'b1;
    repeat (2) @(negedge clk);
    chk(ack == 0, "R1 ack too early", ack, 0);
    @(negedge clk);
    chk(ack == 1, "R1 ack latency", ack, 1);
    @(negedge clk);
    chk(ack == 0, "R3 single one-cycle strobe", ack, 0);
    repeat (20) @(negedge clk);
    req = 1'b0;
    drain("R2 held high no retrigger");

    push(1, 0, "R3 single cnt");
    pulse(3);
    drain("R3 second trigger");
    chk(done == 0, "R6 done early", done, 0);
    push(0, 0, "R3 single cnt");
    pulse(3);
    drain("R3 third trigger");
    chk(done == 1, "R6 done at zero", done, 1);

    // zero count: triggers ignored
    pulse(3);
    drain("R5 no move at zero");
    chk(cnt == 0, "R5 cnt stays zero", cnt, 0);

    // successive mode, request dropped early
    mode = 1'b1;
    load(5);
    chk(done == 0, "R8 done cleared on load", done, 0);
    push(4, 0, "R4 succ cnt");
    push(3, 1, "R7 succ cnt"); push(2, 1, "R4 succ cnt");
    push(1, 1, "R4 succ cnt"); push(0, 1, "R4 succ cnt");
    pulse(2);
    drain("R7 burst survives deassert");
    chk(done == 1, "R6 done after burst", done, 1);

    // re-arm with request held high
    mode = 1'b0;
    req = 1'b1;
    repeat (6) @(negedge clk);
    load(2);
    push(1, 0, "R8 rearm trigger");
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R8 rearm single", q.size(), 0);
    req = 1'b0;
    drain("R8 rearm once");

    // load colliding with a burst move
    mode = 1'b1;
    load(4);
    push(3, 0, "R4 succ first");
    req = 1'b1;
    repeat (3) @(negedge clk);
    ld = 1'b1; val = CW'(2);
    @(negedge clk);
    ld = 1'b0;
    push(1, 0, "R9 after load"); push(0, 1, "R9 after load");
    chk(ack == 0, "R9 load suppresses move", ack, 0);
    chk(cnt == 2, "R9 load value wins", cnt, 2);
    repeat (5) @(negedge clk);
    req = 1'b0;
    drain("R9 burst of new count");

    // disabled channel
    en = 1'b0;
    load(3);
    pulse(3);
    drain("R10 disabled no move");
    chk(cnt == 3, "R10 cnt unchanged", cnt, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule